// File: doc/BRIEF.md
# SPI Master Burst Sequencer

This block is the transfer sequencer inside an SPI master. It drains 32-bit words from an external transmit queue and sends them as a burst whose length in bits is programmable. A burst can be shorter than one word, or it can span several words under one chip select. Every byte that comes back from the slave is packed into a receive word, and the full word is handed to an external receive queue. The block also reports when a transfer has completed and when a received word was lost.

Control fields come from a register block that sits beside it. These fields are the enable, the channel select, a per-channel master bit, the burst length, the start mode, the exchange bit and a per-channel wave bit. Two start modes are supported. In the first, the engine runs as soon as there is data to send. In the second, it waits for a software-driven exchange request. The wave bit makes the engine run bursts back to back until the transmit queue is empty. It re-requests the exchange bit at each burst start and clears it when the queue is empty. The serial clock is a fixed divide of the system clock, in mode 0 only (clock idles low, input sampled on the rising edge, output changed on the falling edge).

Top module: `spi_burst_engine`

## Requirements
- R1: A burst carries `burstField`+1 bits. A remaining-bit counter is reloaded at the start of each burst. Each word sends ceil(min(remaining, 32)/8) bytes, and each byte takes 8 off the counter. For example, a field of 11 sends 2 bytes from a single word and ends the burst.
- R2: Bytes of a transmit word go out least significant byte first, each byte MSB first. `sclk` idles low, `miso` is sampled when `sclk` rises, and `mosi` changes only when `sclk` falls.
- R3: Received bytes are packed in arrival order: the first into bits [7:0], the next into [15:8], and so on. Unused upper bytes are zero. One word is offered per transmit word.
- R4: When a receive word is ready while `rxFull` is high, the word is dropped (no `rxPush`) and `rxOverflow` pulses for one cycle.
- R5: With `enable` high and `chanMaster[chanSel]` set, `csN[chanSel]` is 0 and the other chip selects are 1. Otherwise all chip selects are 1.
- R6: With `autoStart` high, the engine begins sending whenever the transmit queue is non-empty. This covers a word written while `autoStart` is high, and `autoStart` being raised while words are waiting.
- R7: With `autoStart` low, nothing is sent until `xchBit` goes from 0 to 1.
- R8: In wave mode (`autoStart` low and `waveCfg[chanSel]` set on a master channel), a finished burst is followed by the next burst without a new request. `xchSet` pulses at the start of every burst.
- R9: A burst that ends outside wave mode pulses `xferDone` and stops the engine. When the transmit queue is empty at the end of a word, `xferDone` and `xchClr` both pulse and the engine stops. An exchange request with an empty queue also pulses both.
- R10: A burst longer than 32 bits continues into the next transmit word under the same chip select. `xferDone` pulses once, at the end of the burst.
- R11: Clearing `enable` aborts any transfer within one cycle. After the abort, `sclk` and `mosi` are low, all chip selects are high, and no further push or done is produced.
- R12: After reset, `sclk` is low, `txPop` and `rxPush` are low, and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and idles |
| chanSel | input | $clog2(NUM_CS) | Selected chip-select channel |
| chanMaster | input | NUM_CS | Per-channel master mode bit |
| waveCfg | input | NUM_CS | Per-channel back-to-back burst bit |
| burstField | input | BURST_W | Burst length in bits minus one |
| autoStart | input | 1 | 1: start when data is present; 0: start on exchange request |
| xchBit | input | 1 | Exchange request bit from the control register |
| txEmpty | input | 1 | Transmit queue is empty |
| txData | input | WORD_W | Head word of the transmit queue |
| txPop | output | 1 | Removes the head transmit word |
| rxFull | input | 1 | Receive queue is full |
| rxPush | output | 1 | Writes rxData into the receive queue |
| rxData | output | WORD_W | Assembled receive word |
| xferDone | output | 1 | Transfer-complete pulse |
| rxOverflow | output | 1 | Receive-word-dropped pulse |
| xchSet | output | 1 | Request to set the exchange bit |
| xchClr | output | 1 | Request to clear the exchange bit |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the engine with `CLK_HALF`=2, so each byte takes only 32 system cycles. With that setting, dozens of bytes fit into short directed scenarios. `BURST_W`=8 still reaches bursts that span two words with a partial last word (40 bits), as well as odd lengths such as 12 bits. The default word width and four channels are kept, so the chip-select decode and least-significant-byte-first packing are checked at full size. A bench slave returns a known byte sequence, and the bench models the transmit queue, the receive queue and the exchange bit. Together these cover the overflow, wave and stop cases.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP,
    ST_SEND,
    ST_WAIT,
    ST_WEND
  } engState_t;

  // strobes from the sequencer into the shifter
  typedef struct packed {
    logic loadWord;
    logic startByte;
    logic abort;
  } dpCtl_t;

endpackage

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rxData,
  output logic              byteDone
);

  localparam int BYTES  = WORD_W / 8;
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int DIV_W  = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] rxWord;
  logic [IDX_W-1:0]  byteIdx;
  logic [7:0]        shOut;
  logic [7:0]        shIn;
  logic [2:0]        bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              busy;
  logic              tick;

  assign tick   = (divCnt == DIV_W'(CLK_HALF - 1));
  assign mosi   = busy ? shOut[7] : 1'b0;
  assign rxData = rxWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord   <= '0;
      rxWord   <= '0;
      byteIdx  <= '0;
      shOut    <= '0;
      shIn     <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      busy     <= 1'b0;
      sclk     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (dpCtl.abort) begin
        busy   <= 1'b0;
        sclk   <= 1'b0;
        divCnt <= '0;
      end else begin
        if (dpCtl.loadWord) begin
          txWord  <= txData;
          rxWord  <= '0;
          byteIdx <= '0;
        end
        if (dpCtl.startByte) begin
          shOut  <= txWord[{byteIdx, 3'b000} +: 8];
          busy   <= 1'b1;
          bitCnt <= '0;
          divCnt <= '0;
          sclk   <= 1'b0;
        end else if (busy) begin
          if (tick) begin
            divCnt <= '0;
            sclk   <= ~sclk;
            if (!sclk) begin
              // rising edge: capture input
              shIn <= {shIn[6:0], miso};
            end else if (bitCnt == 3'd7) begin
              // falling edge after the eighth bit
              busy     <= 1'b0;
              byteDone <= 1'b1;
              rxWord[{byteIdx, 3'b000} +: 8] <= shIn;
              byteIdx  <= byteIdx + IDX_W'(1);
            end else begin
              bitCnt <= bitCnt + 3'd1;
              shOut  <= {shOut[6:0], 1'b0};
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
      end
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk)
    else $error("serial clock high while shifter idle");

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dpCtl.abort && $rose(sclk)) |-> $stable(mosi))
    else $error("mosi moved on a rising clock edge");

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int NUM_CS  = 4,
  parameter int BURST_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [$clog2(NUM_CS)-1:0] chanSel,
  input  logic [NUM_CS-1:0]         chanMaster,
  input  logic [NUM_CS-1:0]         waveCfg,
  input  logic [BURST_W-1:0]        burstField,
  input  logic                      autoStart,
  input  logic                      xchBit,
  input  logic                      txEmpty,
  output logic                      txPop,
  input  logic                      rxFull,
  output logic                      rxPush,
  output logic                      xferDone,
  output logic                      rxOverflow,
  output logic                      xchSet,
  output logic                      xchClr,
  output logic [NUM_CS-1:0]         csN,
  input  logic                      byteDone,
  output dpCtl_t                    dpCtl
);

  localparam int CNT_W = BURST_W + 2;
  localparam int BYTES = WORD_W / 8;
  localparam int BL_W  = $clog2(BYTES) + 1;
  localparam int BIT_W = $clog2(WORD_W) + 2;

  engState_t         state;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  newRem;
  logic [BL_W-1:0]   bytesLeft;
  logic [BL_W-1:0]   wordBytes;
  logic [BIT_W-1:0]  capBits;
  logic [BIT_W-1:0]  roundBits;
  logic              xchPrev;
  logic              xchRise;
  logic              chanIsMaster;
  logic              runOk;
  logic              waveMode;
  logic              remNonPos;
  logic              endBurst;
  logic              emptyReq;

  assign chanIsMaster = chanMaster[chanSel];
  assign runOk        = enable && chanIsMaster;
  assign waveMode     = chanIsMaster && !autoStart && waveCfg[chanSel];
  assign xchRise      = xchBit && !xchPrev;
  assign remNonPos    = remain[CNT_W-1] || (remain == '0);
  assign endBurst     = remNonPos && !waveMode;
  assign emptyReq     = (state == ST_IDLE) && runOk && !autoStart && xchRise && txEmpty;

  // bits for the next word and the byte count they round up to
  always_comb begin
    newRem    = remNonPos ? ({2'b00, burstField} + CNT_W'(1)) : remain;
    capBits   = (newRem > CNT_W'(WORD_W)) ? BIT_W'(WORD_W) : newRem[BIT_W-1:0];
    roundBits = capBits + BIT_W'(7);
    wordBytes = BL_W'(roundBits >> 3);
  end

  // chip select decode
  always_comb begin
    csN = '1;
    if (runOk) csN[chanSel] = 1'b0;
  end

  assign txPop      = (state == ST_POP);
  assign rxPush     = (state == ST_WEND) && !rxFull;
  assign rxOverflow = (state == ST_WEND) && rxFull;
  assign xchSet     = (state == ST_POP) && remNonPos && waveMode;
  assign xferDone   = ((state == ST_WEND) && (endBurst || txEmpty)) || emptyReq;
  assign xchClr     = ((state == ST_WEND) && txEmpty) || emptyReq;

  assign dpCtl.loadWord  = (state == ST_POP);
  assign dpCtl.startByte = (state == ST_SEND);
  assign dpCtl.abort     = !enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remain    <= '0;
      bytesLeft <= '0;
      xchPrev   <= 1'b0;
    end else begin
      xchPrev <= xchBit;
      if (!enable) begin
        state  <= ST_IDLE;
        remain <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (runOk && !txEmpty && (autoStart || xchRise)) state <= ST_POP;
          end
          ST_POP: begin
            remain    <= newRem;
            bytesLeft <= wordBytes;
            state     <= ST_SEND;
          end
          ST_SEND: state <= ST_WAIT;
          ST_WAIT: begin
            if (byteDone) begin
              remain <= remain - CNT_W'(8);
              if (bytesLeft > BL_W'(1)) begin
                bytesLeft <= bytesLeft - BL_W'(1);
                state     <= ST_SEND;
              end else begin
                state <= ST_WEND;
              end
            end
          end
          ST_WEND: begin
            if (endBurst || txEmpty) state <= ST_IDLE;
            else                     state <= ST_POP;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty)
    else $error("pop from empty transmit queue");

  // R4
  rx_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull)
    else $error("push into full receive queue");

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE))
    else $error("engine active after disable");

  // R5
  cs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state != ST_IDLE) |-> !csN[chanSel])
    else $error("transfer without its chip select");

  // R8
  xch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(xchSet && xchClr))
    else $error("exchange set and clear together");

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NUM_CS   = 4,
  parameter int BURST_W  = 12,
  parameter int CLK_HALF = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [$clog2(NUM_CS)-1:0] chanSel,
  input  logic [NUM_CS-1:0]         chanMaster,
  input  logic [NUM_CS-1:0]         waveCfg,
  input  logic [BURST_W-1:0]        burstField,
  input  logic                      autoStart,
  input  logic                      xchBit,
  input  logic                      txEmpty,
  input  logic [WORD_W-1:0]         txData,
  output logic                      txPop,
  input  logic                      rxFull,
  output logic                      rxPush,
  output logic [WORD_W-1:0]         rxData,
  output logic                      xferDone,
  output logic                      rxOverflow,
  output logic                      xchSet,
  output logic                      xchClr,
  output logic                      sclk,
  output logic                      mosi,
  input  logic                      miso,
  output logic [NUM_CS-1:0]         csN
);

  dpCtl_t dpCtl;
  logic   byteDone;

  spi_burst_ctrl #(
    .WORD_W (WORD_W),
    .NUM_CS (NUM_CS),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .chanSel   (chanSel),
    .chanMaster(chanMaster),
    .waveCfg   (waveCfg),
    .burstField(burstField),
    .autoStart (autoStart),
    .xchBit    (xchBit),
    .txEmpty   (txEmpty),
    .txPop     (txPop),
    .rxFull    (rxFull),
    .rxPush    (rxPush),
    .xferDone  (xferDone),
    .rxOverflow(rxOverflow),
    .xchSet    (xchSet),
    .xchClr    (xchClr),
    .csN       (csN),
    .byteDone  (byteDone),
    .dpCtl     (dpCtl)
  );

  spi_burst_dp #(
    .WORD_W  (WORD_W),
    .CLK_HALF(CLK_HALF)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .txData  (txData),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .rxData  (rxData),
    .byteDone(byteDone)
  );

endmodule

// File: tb/tb_spi_burst_engine.sv
`timescale 1ns/1ps
module tb_spi_burst_engine;

  localparam int WORD_W = 32;
  localparam int NUM_CS = 4;
  localparam int BURST_W = 8;
  localparam int CLK_HALF = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] chanSel = 2'd0;
  logic [NUM_CS-1:0] chanMaster = '0;
  logic [NUM_CS-1:0] waveCfg = '0;
  logic [BURST_W-1:0] burstField = '0;
  logic autoStart = 1'b0;
  logic xchReg = 1'b0;
  logic txEmpty, txPop, rxFull, rxPush, xferDone, rxOverflow, xchSet, xchClr;
  logic sclk, mosi;
  logic miso = 1'b1;
  logic [WORD_W-1:0] txData, rxData;
  logic [NUM_CS-1:0] csN;

  // bench queues and counters
  logic [31:0] txMem [0:15];
  logic [31:0] rxMem [0:63];
  logic [7:0]  capMem [0:127];
  int txHead = 0, txTail = 0, rxCount = 0, rxCap = 1000;
  int doneCnt = 0, ovfCnt = 0, setCnt = 0, capCount = 0;
  int checks = 0, errors = 0;
  logic swStb = 1'b0, swVal = 1'b0;
  logic [7:0] sRx = 8'h00;
  logic [7:0] sResp = 8'hA0;
  int sBit = 0;

  assign txEmpty = (txHead == txTail);
  assign txData  = txMem[txHead[3:0]];
  assign rxFull  = (rxCount >= rxCap);

  always #10 clk = ~clk;

  spi_burst_engine #(
    .WORD_W(WORD_W), .NUM_CS(NUM_CS), .BURST_W(BURST_W), .CLK_HALF(CLK_HALF)
  ) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .chanSel(chanSel),
    .chanMaster(chanMaster), .waveCfg(waveCfg), .burstField(burstField),
    .autoStart(autoStart), .xchBit(xchReg), .txEmpty(txEmpty), .txData(txData),
    .txPop(txPop), .rxFull(rxFull), .rxPush(rxPush), .rxData(rxData),
    .xferDone(xferDone), .rxOverflow(rxOverflow), .xchSet(xchSet),
    .xchClr(xchClr), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // queue, register and event models
  always @(posedge clk) begin
    if (txPop) txHead <= txHead + 1;
    if (rxPush) begin
      rxMem[rxCount[5:0]] <= rxData;
      rxCount <= rxCount + 1;
    end
    if (xferDone) doneCnt <= doneCnt + 1;
    if (rxOverflow) ovfCnt <= ovfCnt + 1;
    if (xchSet) setCnt <= setCnt + 1;
    if (xchClr) xchReg <= 1'b0;
    else if (xchSet) xchReg <= 1'b1;
    else if (swStb) xchReg <= swVal;
  end

  function automatic logic [7:0] respOf(input int k);
    return 8'hA0 + k[7:0];
  endfunction

  // mode 0 slave: sample on rise, present next bit on fall, MSB first
  always @(posedge sclk) begin
    sRx = {sRx[6:0], mosi};
    sBit = sBit + 1;
    if (sBit == 8) begin
      capMem[capCount[6:0]] = sRx;
      capCount = capCount + 1;
      sBit = 0;
      sResp = respOf(capCount);
    end
  end
  always @(negedge sclk) miso = sResp[7 - sBit];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pushTx(input logic [31:0] w);
    txMem[txTail[3:0]] = w;
    txTail = txTail + 1;
  endtask

  task automatic setXch(input logic v);
    @(negedge clk); swVal = v; swStb = 1'b1;
    @(negedge clk); swStb = 1'b0;
  endtask

  task automatic waitDone(input int target, input string req);
    int n = 0;
    while (doneCnt < target && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(req, "done reached", (doneCnt >= target), 1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R12", "csN after reset", csN, 4'hF);
    chk("R12", "sclk after reset", sclk, 1'b0);
    chk("R12", "txPop after reset", txPop, 1'b0);
    chk("R12", "rxPush after reset", rxPush, 1'b0);
  endtask

  task automatic testCs();
    @(negedge clk);
    enable = 1'b1; chanMaster = 4'b1111; chanSel = 2'd2;
    @(negedge clk);
    chk("R5", "csN channel 2", csN, 4'b1011);
    chanSel = 2'd0; @(negedge clk);
    chk("R5", "csN channel 0", csN, 4'b1110);
    chanMaster = 4'b1110; @(negedge clk);
    chk("R5", "csN non-master channel", csN, 4'hF);
    chanMaster = 4'b1111; chanSel = 2'd1; @(negedge clk);
    chk("R5", "csN channel 1", csN, 4'b1101);
  endtask

  task automatic testImm8();
    int b = capCount; int d = doneCnt; int r = rxCount;
    @(negedge clk); burstField = 8'd7; autoStart = 1'b1;
    pushTx(32'h11223344);
    waitDone(d + 1, "R6");
    chk("R1", "bytes for 8-bit burst", capCount - b, 1);
    chk("R2", "first byte is LSB", capMem[b[6:0]], 8'h44);
    chk("R3", "rx word 8-bit", rxMem[r[5:0]], {24'h0, respOf(b)});
    chk("R2", "sclk idle low", sclk, 1'b0);
  endtask

  task automatic testImm32();
    int b = capCount; int d = doneCnt; int r = rxCount;
    @(negedge clk); burstField = 8'd31;
    pushTx(32'hDEADBEEF);
    waitDone(d + 1, "R1");
    chk("R1", "bytes for 32-bit burst", capCount - b, 4);
    chk("R2", "byte order", {capMem[b[6:0]+3], capMem[b[6:0]+2], capMem[b[6:0]+1], capMem[b[6:0]]}, 32'hDEADBEEF);
    chk("R3", "rx packing", rxMem[r[5:0]], {respOf(b+3), respOf(b+2), respOf(b+1), respOf(b)});
  endtask

  task automatic testChain();
    int b = capCount; int d = doneCnt; int r = rxCount;
    @(negedge clk); burstField = 8'd39;
    pushTx(32'h04030201); pushTx(32'h0C0B0A05);
    waitDone(d + 1, "R10");
    chk("R10", "bytes for 40-bit burst", capCount - b, 5);
    for (int i = 0; i < 5; i++)
      chk("R10", "chained byte", capMem[b[6:0] + i[6:0]], 8'(i + 1));
    chk("R10", "rx words", rxCount - r, 2);
    chk("R3", "second rx word partial", rxMem[r[5:0] + 1], {24'h0, respOf(b + 4)});
    chk("R10", "single done", doneCnt - d, 1);
  endtask

  task automatic testOdd();
    int b = capCount; int d = doneCnt; int r = rxCount;
    @(negedge clk); burstField = 8'd11;
    pushTx(32'h0000BEAD);
    waitDone(d + 1, "R1");
    chk("R1", "bytes for 12-bit burst", capCount - b, 2);
    chk("R3", "rx word 12-bit", rxMem[r[5:0]], {16'h0, respOf(b + 1), respOf(b)});
  endtask

  task automatic testSetAuto();
    int b; int d;
    @(negedge clk); autoStart = 1'b0; burstField = 8'd7; waveCfg = 4'h0;
    b = capCount; d = doneCnt;
    pushTx(32'h0000005A);
    repeat (60) @(negedge clk);
    chk("R6", "nothing sent before start", capCount - b, 0);
    autoStart = 1'b1;
    waitDone(d + 1, "R6");
    chk("R6", "sent after start bit set", capMem[b[6:0]], 8'h5A);
  endtask

  task automatic testExchange();
    int b; int d;
    @(negedge clk); autoStart = 1'b0; burstField = 8'd7;
    b = capCount; d = doneCnt;
    pushTx(32'h000000C1); pushTx(32'h000000C2);
    repeat (60) @(negedge clk);
    chk("R7", "idle without request", capCount - b, 0);
    setXch(1'b1);
    waitDone(d + 1, "R7");
    repeat (60) @(negedge clk);
    chk("R9", "stop after burst", capCount - b, 1);
    chk("R9", "one word left", txTail - txHead, 1);
    chk("R7", "first exchange byte", capMem[b[6:0]], 8'hC1);
    setXch(1'b0); setXch(1'b1);
    waitDone(d + 2, "R7");
    chk("R7", "second exchange byte", capMem[b[6:0] + 1], 8'hC2);
    chk("R9", "exchange cleared on empty", xchReg, 1'b0);
  endtask

  task automatic testEmptyReq();
    int d = doneCnt;
    setXch(1'b1);
    repeat (4) @(negedge clk);
    chk("R9", "done on empty request", doneCnt - d, 1);
    chk("R9", "exchange cleared", xchReg, 1'b0);
  endtask

  task automatic testWave();
    int b; int d; int s;
    @(negedge clk); waveCfg = 4'b0010; burstField = 8'd7;
    b = capCount; d = doneCnt; s = setCnt;
    pushTx(32'h000000E1); pushTx(32'h000000E2); pushTx(32'h000000E3);
    setXch(1'b1);
    waitDone(d + 1, "R8");
    repeat (60) @(negedge clk);
    chk("R8", "all bursts sent", capCount - b, 3);
    chk("R8", "set pulse per burst", setCnt - s, 3);
    chk("R9", "done once in wave", doneCnt - d, 1);
    chk("R9", "exchange cleared after wave", xchReg, 1'b0);
    chk("R8", "third wave byte", capMem[b[6:0] + 2], 8'hE3);
    waveCfg = 4'h0;
  endtask

  task automatic testOverflow();
    int b; int d; int r; int o;
    @(negedge clk); burstField = 8'd7;
    b = capCount; d = doneCnt; r = rxCount; o = ovfCnt;
    rxCap = rxCount + 1; autoStart = 1'b1;
    pushTx(32'h00000071); pushTx(32'h00000072);
    waitDone(d + 2, "R4");
    chk("R4", "only one word stored", rxCount - r, 1);
    chk("R4", "overflow pulses", ovfCnt - o, 1);
    chk("R4", "both bytes still sent", capCount - b, 2);
    rxCap = 1000;
  endtask

  task automatic testDisable();
    int d; int r;
    @(negedge clk); burstField = 8'd31; autoStart = 1'b1;
    d = doneCnt; r = rxCount;
    pushTx(32'h87654321);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "csN released", csN, 4'hF);
    chk("R11", "sclk low", sclk, 1'b0);
    chk("R11", "mosi low", mosi, 1'b0);
    repeat (200) @(negedge clk);
    chk("R11", "no push after abort", rxCount - r, 0);
    chk("R11", "no done after abort", doneCnt - d, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testCs();
    testImm8();
    testImm32();
    testChain();
    testOdd();
    testSetAuto();
    testExchange();
    testEmptyReq();
    testWave();
    testOverflow();
    testDisable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule